// File: doc/BRIEF.md
# SMBus Alert Line Controller

This block manages the optional SMBus alert wire for a device that can act either as a target or as a host. A role input picks the behaviour. In target role a single enable pulls the shared open-drain alert wire low. The same enable arms a comparator that tells an external byte engine to acknowledge the alert response address, so the device answers that address only while it is the one holding the wire low.

In host role the block passes the wire through a two-flop synchronizer and watches for a high-to-low transition. When it sees one, it sets a sticky alert flag. Software clears the flag with a one-cycle clear pulse. An interrupt request is the flag gated by an error-interrupt enable. With the enable low the wire is released, and the internal alert level reads as high whatever the pin does, so the pin can serve as a general-purpose line.

Byte transfer, arbitration and bus clock generation belong to the surrounding I2C engine. That engine presents each received address byte with a valid strobe and reads back the acknowledge decision one cycle later.

Top module: `smb_alert_ctrl`

## Requirements
- R1: While reset is held low, and after it is released with no stimulus, `pin_pull_o`, `addr_ack_o`, `alert_flag_o` and `irq_o` are all 0.
- R2: In target role (`host_role_i`=0) with `alert_en_i`=1, `pin_pull_o` is 1 from the first rising edge after the enable is seen. When the enable returns to 0, `pin_pull_o` is 0 from the next rising edge.
- R3: An address byte strobed by `addr_valid_i` whose bits [7:1] equal 7'b0001100 is acknowledged (`addr_ack_o`=1 one cycle after the strobe) for either value of bit 0, but only if `pin_pull_o` was 1 in the strobe cycle. Any other byte, and any byte while the wire is not pulled, gives `addr_ack_o`=0.
- R4: In host role with `alert_en_i`=1, a high-to-low change on `alert_pin_i` sets `alert_flag_o` on the third rising edge after the change (two synchronizer stages plus the flag register). In target role no pin activity sets the flag.
- R5: With `alert_en_i`=0 the internal alert level is treated as high, so a low pin sets no flag. Raising the enable in host role while the synchronized pin is already low counts as a falling edge, and the flag sets on the next rising edge.
- R6: `alert_flag_o` stays 1 until a cycle with `flag_clr_i`=1. A clear in the same cycle as a detected edge leaves the flag at 1.
- R7: `irq_o` equals `alert_flag_o` AND `err_irq_en_i`, combinationally.
- R8: The block only ever asks to pull the wire low (`pin_pull_o`=1 means drive 0) and never drives it high. In host role `pin_pull_o` is 0 from the first rising edge after host role is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_role_i | input | 1 | 1 selects host role, 0 selects target role |
| alert_en_i | input | 1 | Alert enable shared by both roles |
| err_irq_en_i | input | 1 | Error-interrupt enable |
| alert_pin_i | input | 1 | Asynchronous level of the alert wire |
| pin_pull_o | output | 1 | Open-drain enable: 1 drives the wire to 0, 0 releases it |
| addr_valid_i | input | 1 | Strobe for a received address byte |
| addr_byte_i | input | 8 | Address byte, 7-bit address in [7:1], read/write in [0] |
| addr_ack_o | output | 1 | Acknowledge decision, one cycle after the strobe |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the alert flag |
| alert_flag_o | output | 1 | Sticky alert flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth, or a previous-level register loaded from the raw pin rather than the gated level, shows up as the flag rising one cycle early or late. It also shows up as a flag that rises, or stays low, when the enable switches with the pin already low. A pull register that is armed separately from the address comparator shows as an acknowledge in the very cycle the enable first appears, one edge before the wire is pulled. A flag whose clear takes priority over a new edge reads 0 right after a clear that coincides with a falling edge. Each of these shows on the ports within three clock edges of the triggering stimulus.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
    localparam int unsigned ADDR_BYTE_W = 8;
    localparam int unsigned ADDR_W      = ADDR_BYTE_W - 1;
    localparam logic [ADDR_W-1:0] RESP_ADDR = 7'b0001100;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic prev_lvl;
        logic flag;
    } host_state_t;

    typedef struct packed {
        logic pull;
        logic ack;
    } tgt_state_t;
endpackage

// File: rtl/smb_alert_sync.sv
module smb_alert_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{IDLE}};
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/smb_alert_host.sv
module smb_alert_host
    import smb_alert_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic host_role_i,
    input  logic alert_en_i,
    input  logic pin_sync_i,
    input  logic flag_clr_i,
    input  logic err_irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    host_state_t st_d, st_q;
    logic        gated_lvl;
    logic        fall;

    always_comb begin
        gated_lvl   = (host_role_i && alert_en_i) ? pin_sync_i : 1'b1;
        fall        = st_q.prev_lvl && !gated_lvl;
        st_d        = st_q;
        st_d.prev_lvl = gated_lvl;
        st_d.flag   = (st_q.flag && !flag_clr_i) || fall;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev_lvl: 1'b1, flag: 1'b0};
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag && err_irq_en_i;

    AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q.flag) && !$past(flag_clr_i)) |-> st_q.flag); // R6
    AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.flag) |-> $past(alert_en_i && host_role_i)); // R4
    AST_CLEAR_LOSES_TO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(flag_clr_i && fall) |-> st_q.flag); // R6
endmodule

// File: rtl/smb_alert_target.sv
module smb_alert_target
    import smb_alert_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   host_role_i,
    input  logic                   alert_en_i,
    input  logic                   addr_valid_i,
    input  logic [ADDR_BYTE_W-1:0] addr_byte_i,
    output logic                   pull_o,
    output logic                   ack_o
);
    tgt_state_t st_d, st_q;
    logic       addr_hit;

    always_comb begin
        addr_hit  = (addr_byte_i[ADDR_BYTE_W-1:1] == RESP_ADDR);
        st_d      = st_q;
        st_d.pull = !host_role_i && alert_en_i;
        st_d.ack  = addr_valid_i && addr_hit && st_q.pull;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pull_o = st_q.pull;
    assign ack_o  = st_q.ack;

    AST_ACK_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ack |-> $past(addr_valid_i)); // R3
    AST_HOST_NO_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(host_role_i) |-> !st_q.pull); // R8
endmodule

// File: rtl/smb_alert_ctrl.sv
module smb_alert_ctrl
    import smb_alert_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   host_role_i,
    input  logic                   alert_en_i,
    input  logic                   err_irq_en_i,
    input  logic                   alert_pin_i,
    output logic                   pin_pull_o,
    input  logic                   addr_valid_i,
    input  logic [ADDR_BYTE_W-1:0] addr_byte_i,
    output logic                   addr_ack_o,
    input  logic                   flag_clr_i,
    output logic                   alert_flag_o,
    output logic                   irq_o
);
    logic pin_sync;

    smb_alert_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (alert_pin_i),
        .sync_o  (pin_sync)
    );

    smb_alert_host u_host (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .host_role_i  (host_role_i),
        .alert_en_i   (alert_en_i),
        .pin_sync_i   (pin_sync),
        .flag_clr_i   (flag_clr_i),
        .err_irq_en_i (err_irq_en_i),
        .flag_o       (alert_flag_o),
        .irq_o        (irq_o)
    );

    smb_alert_target u_tgt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .host_role_i  (host_role_i),
        .alert_en_i   (alert_en_i),
        .addr_valid_i (addr_valid_i),
        .addr_byte_i  (addr_byte_i),
        .pull_o       (pin_pull_o),
        .ack_o        (addr_ack_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (!rst_ni || (!alert_flag_o && !addr_ack_o))); // R1
endmodule

// File: tb/smb_alert_ctrl_test.sv
module smb_alert_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_role = 1'b0, alert_en = 1'b0, err_ie = 1'b0;
    logic       pin = 1'b1, addr_valid = 1'b0, clr = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       pull, ack, flag, irq;
    int         vectors = 0, miscompares = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    smb_alert_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .host_role_i(host_role), .alert_en_i(alert_en),
        .err_irq_en_i(err_ie), .alert_pin_i(pin), .pin_pull_o(pull),
        .addr_valid_i(addr_valid), .addr_byte_i(addr_byte), .addr_ack_o(ack),
        .flag_clr_i(clr), .alert_flag_o(flag), .irq_o(irq)
    );

    task automatic check(input logic got, input logic exp, input string req);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {host_role, alert_en, addr_byte, expected ack}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 1'b1, 8'h18, 1'b1},
        {1'b0, 1'b1, 8'h19, 1'b1},
        {1'b0, 1'b1, 8'h1A, 1'b0},
        {1'b0, 1'b1, 8'h30, 1'b0},
        {1'b0, 1'b0, 8'h18, 1'b0},
        {1'b1, 1'b1, 8'h18, 1'b0},
        {1'b0, 1'b1, 8'h98, 1'b0},
        {1'b1, 1'b0, 8'h19, 1'b0}
    };

    initial begin
        cycles(3);
        check(pull, 1'b0, "R1"); check(ack, 1'b0, "R1");
        check(flag, 1'b0, "R1"); check(irq, 1'b0, "R1");
        rst_n = 1'b1;
        cycles(2);
        check(pull, 1'b0, "R1"); check(flag, 1'b0, "R1");

        // Address table: R3 ack decisions, R2/R8 pull level
        for (int v = 0; v < 8; v++) begin
            host_role = VEC[v][10]; alert_en = VEC[v][9];
            cycles(1);
            addr_valid = 1'b1; addr_byte = VEC[v][8:1];
            cycles(1);
            addr_valid = 1'b0;
            check(ack, VEC[v][0], "R3");
            check(pull, !VEC[v][10] && VEC[v][9], "R2/R8");
        end

        // R3: enable and address together -> no ack until the wire is pulled
        host_role = 1'b0; alert_en = 1'b0; cycles(2);
        alert_en = 1'b1; addr_valid = 1'b1; addr_byte = 8'h18;
        cycles(1);
        check(pull, 1'b1, "R2"); check(ack, 1'b0, "R3");
        cycles(1);
        addr_valid = 1'b0;
        check(ack, 1'b1, "R3");
        // R2 release
        alert_en = 1'b0; cycles(1);
        check(pull, 1'b0, "R2");

        // R4 target role: low pin sets no flag
        alert_en = 1'b1; pin = 1'b0; cycles(5);
        check(flag, 1'b0, "R4");
        pin = 1'b1; cycles(4);

        // R4 host role falling edge latency
        host_role = 1'b1; cycles(1);
        check(pull, 1'b0, "R8");
        cycles(3);
        pin = 1'b0;
        cycles(2); check(flag, 1'b0, "R4");
        cycles(1); check(flag, 1'b1, "R4");
        check(irq, 1'b0, "R7");
        err_ie = 1'b1; #1;
        check(irq, 1'b1, "R7");
        // R6 sticky
        pin = 1'b1; cycles(4);
        check(flag, 1'b1, "R6");
        // R6 clear and edge same cycle
        pin = 1'b0; cycles(2);
        clr = 1'b1; cycles(1); clr = 1'b0;
        check(flag, 1'b1, "R6");
        clr = 1'b1; cycles(1); clr = 1'b0;
        check(flag, 1'b0, "R6"); check(irq, 1'b0, "R7");

        // R5 enable low masks the pin
        pin = 1'b1; alert_en = 1'b0; cycles(4);
        pin = 1'b0; cycles(5);
        check(flag, 1'b0, "R5");
        alert_en = 1'b1; cycles(1);
        check(flag, 1'b1, "R5");
        check(irq, 1'b1, "R7");

        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 5000 && !done; t++) @(posedge clk);
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule